// File: doc/BRIEF.md
# Credit-Based Link Flow Control

This block models one point-to-point link that is governed by a credit window. A sender holds a count of the free buffer slots it may still fill. It launches a flit only while that count is above zero, and each launch costs one credit. The flit crosses a forward delay pipe into a receive FIFO. The downstream consumer drains that FIFO. As entries leave, the receiver collects the freed slots and sends them back over a credit delay pipe as messages that each carry a count.

The sender starts with as many credits as the FIFO has entries. A slot is only granted again after it has been drained and its credit has crossed the return pipe. The FIFO therefore cannot overflow, whatever the link delay is. The round-trip delay still limits throughput when the buffer is shallow. To cut return traffic, drained slots are sent back in bundles. If a bundle stays partly filled because draining stops, the receiver sends it anyway after a fixed idle period.

Top module: `credit_link`

## Requirements
- R1: After reset `credit_level` equals DEPTH, `in_ready` is 1, `out_valid` is 0 and `credit_err` is 0.
- R2: A flit is accepted on a clock edge where `in_valid` and `in_ready` are both 1. When no credit return lands on that edge, `credit_level` drops by exactly one.
- R3: `in_ready` is 0 whenever `credit_level` is 0. With the consumer stalled and `in_valid` held high, exactly DEPTH flits are accepted.
- R4: The receive FIFO is never written while it holds DEPTH entries. After a stalled fill, exactly DEPTH entries drain out.
- R5: Flits leave on `out_data` in acceptance order and unchanged. A flit accepted at edge A into an empty FIFO gives `out_valid` = 1 after edge A+LAT and not before.
- R6: Freed slots are returned in messages of BUNDLE credits. During a continuous drain with no sends, every rise in `credit_level` is exactly BUNDLE.
- R7: A partial bundle is flushed after IDLE_TO consecutive cycles with no drain. For a single drain at edge E0, `credit_level` regains the credit at edge E0+IDLE_TO+LAT and not at the edge before.
- R8: When a send and a credit return fall on the same edge, the new level is the old level minus one plus the returned count, all in that one edge.
- R9: `credit_level` never exceeds DEPTH. `credit_err` goes to 1 and stays there if a return would push it past DEPTH, and stays 0 under legal traffic.
- R10: Once sending stops and the consumer has drained everything, `credit_level` settles back to DEPTH and `out_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Source offers a flit |
| in_data | input | DATA_W | Flit payload from the source |
| in_ready | output | 1 | Sender holds at least one credit |
| out_valid | output | 1 | Receive FIFO is not empty |
| out_data | output | DATA_W | Flit at the head of the receive FIFO |
| out_ready | input | 1 | Consumer drains the head flit |
| credit_level | output | $clog2(DEPTH+1) | Sender's current credit count |
| credit_err | output | 1 | Sticky flag: credit count would have passed DEPTH |

## Verification
Some properties are checked on every clock cycle: no write into a full FIFO, the sender's one-step credit arithmetic for a send alone and for a send together with a return, the size limit of every return message, and the credit bound. Other behaviour only shows up over a whole scenario: end-to-end ordering through both delay pipes, the exact edge on which an idle flush lands at the sender, the acceptance count during a stalled fill, and the return of the full window after a random mix of sends and drains. The bench scenarios cover these.

// File: rtl/cl_pkg.sv
package cl_pkg;

    // width of a counter that must reach n inclusive
    function automatic int cl_cnt_w(input int n);
        return (n < 1) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/cl_pipe.sv
module cl_pipe #(
    parameter int W   = 8,
    parameter int LAT = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_v,
    input  logic [W-1:0] in_d,
    output logic         out_v,
    output logic [W-1:0] out_d
);

    generate
        if (LAT == 0) begin : g_wire
            assign out_v = in_v;
            assign out_d = in_d;
        end else begin : g_regs
            logic [LAT-1:0]        v_d, v_q;
            logic [LAT-1:0][W-1:0] p_d, p_q;

            always_comb begin
                v_d[0] = in_v;
                p_d[0] = in_d;
                for (int i = 1; i < LAT; i++) begin
                    v_d[i] = v_q[i-1];
                    p_d[i] = p_q[i-1];
                end
            end

            always_ff @(posedge clk) begin
                if (!rst_n) begin
                    v_q <= '0;
                    p_q <= '0;
                end else begin
                    v_q <= v_d;
                    p_q <= p_d;
                end
            end

            assign out_v = v_q[LAT-1];
            assign out_d = p_q[LAT-1];
        end
    endgenerate

endmodule

// File: rtl/cl_sender.sv
module cl_sender #(
    parameter int DEPTH = 8,
    parameter int CW    = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flit_req,
    input  logic          ret_valid,
    input  logic [CW-1:0] ret_cnt,
    output logic          send,
    output logic [CW-1:0] level,
    output logic          err
);

    localparam int SW = CW + 1;

    typedef struct packed {
        logic [CW-1:0] credits;
        logic          err;
    } snd_t;

    snd_t          st_d, st_q;
    logic [SW-1:0] sum;

    always_comb begin
        st_d = st_q;
        send = flit_req && (st_q.credits != '0);
        sum  = {1'b0, st_q.credits} - SW'(send)
             + (ret_valid ? {1'b0, ret_cnt} : '0);
        if (sum > SW'(DEPTH)) begin
            st_d.err     = 1'b1;
            st_d.credits = CW'(DEPTH);
        end else begin
            st_d.credits = sum[CW-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q.credits <= CW'(DEPTH);
            st_q.err     <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    assign level = st_q.credits;
    assign err   = st_q.err;

    // R2: a lone send costs exactly one credit
    a_r2_send_decrements: assert property (@(posedge clk) disable iff (!rst_n)
        (send && !ret_valid) |=> (st_q.credits == $past(st_q.credits) - CW'(1)));

    // R8: send and return on the same edge settle in one step
    a_r8_merge_one_step: assert property (@(posedge clk) disable iff (!rst_n)
        (send && ret_valid && !st_d.err) |=>
        (st_q.credits == $past(st_q.credits) - CW'(1) + $past(ret_cnt)));

    // R9: the credit count stays within the initial grant
    a_r9_no_excess: assert property (@(posedge clk) disable iff (!rst_n)
        !st_q.err && (st_q.credits <= CW'(DEPTH)));

endmodule

// File: rtl/cl_receiver.sv
module cl_receiver #(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 8,
    parameter int BUNDLE  = 2,
    parameter int IDLE_TO = 8,
    parameter int CW      = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              out_ready,
    output logic              out_valid,
    output logic [DATA_W-1:0] out_data,
    output logic              ret_valid,
    output logic [CW-1:0]     ret_cnt
);

    localparam int AW = (DEPTH   > 1) ? $clog2(DEPTH)     : 1;
    localparam int BW = $clog2(BUNDLE + 1);
    localparam int TW = (IDLE_TO > 1) ? $clog2(IDLE_TO)   : 1;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] mem;
        logic [AW-1:0]                wr;
        logic [AW-1:0]                rd;
        logic [CW-1:0]                cnt;
        logic [BW-1:0]                acc;
        logic [TW-1:0]                idle;
    } rcv_t;

    rcv_t          st_d, st_q;
    logic          pop;
    logic [BW-1:0] acc_sum;

    always_comb begin
        st_d      = st_q;
        ret_valid = 1'b0;
        ret_cnt   = '0;
        pop       = (st_q.cnt != '0) && out_ready;

        if (push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr = (st_q.wr == AW'(DEPTH - 1)) ? '0 : st_q.wr + AW'(1);
        end
        if (pop) begin
            st_d.rd = (st_q.rd == AW'(DEPTH - 1)) ? '0 : st_q.rd + AW'(1);
        end
        st_d.cnt = st_q.cnt + CW'(push) - CW'(pop);

        acc_sum = st_q.acc + BW'(pop);
        if (acc_sum == BW'(BUNDLE)) begin
            ret_valid = 1'b1;
            ret_cnt   = CW'(acc_sum);
            st_d.acc  = '0;
            st_d.idle = '0;
        end else if (pop) begin
            st_d.acc  = acc_sum;
            st_d.idle = '0;
        end else if (st_q.acc != '0) begin
            if (st_q.idle == TW'(IDLE_TO - 1)) begin
                ret_valid = 1'b1;
                ret_cnt   = CW'(st_q.acc);
                st_d.acc  = '0;
                st_d.idle = '0;
            end else begin
                st_d.idle = st_q.idle + TW'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign out_valid = (st_q.cnt != '0);
    assign out_data  = st_q.mem[st_q.rd];

    // R4: an arriving flit never meets a full FIFO
    a_r4_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (st_q.cnt != CW'(DEPTH)));

    // R6: every return message carries between one and BUNDLE credits
    a_r6_bundle_size: assert property (@(posedge clk) disable iff (!rst_n)
        ret_valid |-> ((ret_cnt != '0) && (ret_cnt <= CW'(BUNDLE))));

    // R7: a partial bundle is held back while draining goes on
    a_r7_no_flush_on_drain: assert property (@(posedge clk) disable iff (!rst_n)
        (ret_valid && (ret_cnt != CW'(BUNDLE))) |-> !pop);

endmodule

// File: rtl/credit_link.sv
module credit_link #(
    parameter int DATA_W  = 16,
    parameter int DEPTH   = 8,
    parameter int LAT     = 2,
    parameter int BUNDLE  = 2,
    parameter int IDLE_TO = 8
) (
    input  logic                                clk,
    input  logic                                rst_n,
    input  logic                                in_valid,
    input  logic [DATA_W-1:0]                   in_data,
    output logic                                in_ready,
    output logic                                out_valid,
    output logic [DATA_W-1:0]                   out_data,
    input  logic                                out_ready,
    output logic [cl_pkg::cl_cnt_w(DEPTH)-1:0]  credit_level,
    output logic                                credit_err
);

    localparam int CW = cl_pkg::cl_cnt_w(DEPTH);

    logic              send;
    logic              fw_v;
    logic [DATA_W-1:0] fw_d;
    logic              rr_v;
    logic [CW-1:0]     rr_c;
    logic              cr_v;
    logic [CW-1:0]     cr_c;

    cl_sender #(.DEPTH(DEPTH), .CW(CW)) u_snd (
        .clk       (clk),
        .rst_n     (rst_n),
        .flit_req  (in_valid),
        .ret_valid (cr_v),
        .ret_cnt   (cr_c),
        .send      (send),
        .level     (credit_level),
        .err       (credit_err)
    );

    assign in_ready = (credit_level != '0);

    cl_pipe #(.W(DATA_W), .LAT(LAT)) u_fwd (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (send),
        .in_d  (in_data),
        .out_v (fw_v),
        .out_d (fw_d)
    );

    cl_receiver #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .BUNDLE(BUNDLE),
        .IDLE_TO(IDLE_TO), .CW(CW)
    ) u_rcv (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (fw_v),
        .push_data (fw_d),
        .out_ready (out_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .ret_valid (rr_v),
        .ret_cnt   (rr_c)
    );

    cl_pipe #(.W(CW), .LAT(LAT)) u_ret (
        .clk   (clk),
        .rst_n (rst_n),
        .in_v  (rr_v),
        .in_d  (rr_c),
        .out_v (cr_v),
        .out_d (cr_c)
    );

    // R3: no flit is launched without a credit
    a_r3_ready_needs_credit: assert property (@(posedge clk) disable iff (!rst_n)
        (credit_level == '0) |-> !send);

endmodule

// File: tb/sim_credit_link.sv
module sim_credit_link;

    localparam int CLK_P   = 10;
    localparam int DATA_W  = 16;
    localparam int DEPTH   = 8;
    localparam int LAT     = 2;
    localparam int BUNDLE  = 2;
    localparam int IDLE_TO = 8;
    localparam int CW      = $clog2(DEPTH + 1);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              in_valid = 1'b0;
    logic [DATA_W-1:0] in_data = '0;
    logic              in_ready;
    logic              out_valid;
    logic [DATA_W-1:0] out_data;
    logic              out_ready = 1'b0;
    logic [CW-1:0]     credit_level;
    logic              credit_err;

    int n_chk = 0;
    int n_bad = 0;
    logic [DATA_W-1:0] sb[$];

    logic        bmon = 1'b0;
    int          b_rises = 0;
    int          b_wrong = 0;
    int          b_pops = 0;
    int          prev_lvl = DEPTH;
    int          err_seen = 0;

    always #(CLK_P/2) clk = ~clk;

    credit_link #(
        .DATA_W(DATA_W), .DEPTH(DEPTH), .LAT(LAT),
        .BUNDLE(BUNDLE), .IDLE_TO(IDLE_TO)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_ready(out_ready), .credit_level(credit_level),
        .credit_err(credit_err)
    );

    function automatic int lvl_after(input int lvl, input int sent, input int ret);
        return lvl - sent + ret;
    endfunction

    function automatic logic ready_for(input int lvl);
        return lvl != 0;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic settle();
        in_valid  = 1'b0;
        out_ready = 1'b1;
        repeat (DEPTH + IDLE_TO + 2*LAT + BUNDLE + 8) step();
        out_ready = 1'b0;
    endtask

    // scoreboard sampled mid-cycle, where inputs and outputs are stable
    always @(negedge clk) begin
        if (rst_n) begin
            if (credit_err) err_seen++;
            if (int'(credit_level) > DEPTH) err_seen++;
            if (bmon && int'(credit_level) > prev_lvl) begin
                b_rises++;
                if (int'(credit_level) - prev_lvl != BUNDLE) b_wrong++;
            end
            prev_lvl = int'(credit_level);
            if (in_valid && in_ready) sb.push_back(in_data);
            if (out_valid && out_ready) begin
                if (bmon) b_pops++;
                if (sb.size() == 0) begin
                    check("R5 pop with nothing sent", 1, 0);
                end else begin
                    check("R5 order/data", int'(out_data), int'(sb.pop_front()));
                end
            end
        end
    end

    initial begin
        #(CLK_P * 150000);
        n_bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        int acc;
        void'($urandom(32'h5eed_c0de));

        repeat (3) step();
        rst_n = 1'b1;
        #1;
        // R1 reset state
        check("R1 level", int'(credit_level), DEPTH);
        check("R1 in_ready", int'(in_ready), 1);
        check("R1 out_valid", int'(out_valid), 0);
        check("R1 err", int'(credit_err), 0);

        // R2 / R5: single flit latency
        in_valid = 1'b1;
        in_data  = 16'hA5C3;
        step();
        in_valid = 1'b0;
        check("R2 level after send", int'(credit_level), lvl_after(DEPTH, 1, 0));
        for (int k = 1; k < LAT; k++) begin
            check("R5 not yet visible", int'(out_valid), 0);
            step();
        end
        check("R5 not yet visible", int'(out_valid), 0);
        step();
        check("R5 visible after LAT", int'(out_valid), 1);
        check("R5 head data", int'(out_data), 16'hA5C3);

        // R7: single drain, partial bundle flushed after idle timeout
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        repeat (IDLE_TO + LAT - 1) step();
        check("R7 credit still outstanding", int'(credit_level), DEPTH - 1);
        step();
        check("R7 credit returned on time", int'(credit_level), DEPTH);

        // R8: send lands on the same edge as a flushed return
        in_valid = 1'b1;
        in_data  = 16'h1111;
        step();
        in_valid = 1'b0;
        repeat (LAT) step();
        out_ready = 1'b1;
        step();
        out_ready = 1'b0;
        repeat (IDLE_TO + LAT - 1) step();
        check("R8 before merge", int'(credit_level), DEPTH - 1);
        in_valid = 1'b1;
        in_data  = 16'h2222;
        step();
        in_valid = 1'b0;
        check("R8 merged level", int'(credit_level), lvl_after(DEPTH - 1, 1, 1));

        settle();
        check("R10 window restored", int'(credit_level), DEPTH);

        // R3 / R4: stalled fill
        acc = 0;
        in_valid = 1'b1;
        for (int k = 0; k < DEPTH + 4; k++) begin
            in_data = DATA_W'(16'h3000 + k);
            if (in_valid && in_ready) acc++;
            step();
        end
        in_valid = 1'b0;
        check("R3 accepted count", acc, DEPTH);
        check("R3 in_ready at zero", int'(in_ready), int'(ready_for(0)));
        check("R3 level zero", int'(credit_level), 0);
        repeat (LAT + 1) step();
        check("R4 fifo holding", int'(out_valid), 1);

        // R6: continuous drain returns whole bundles
        bmon = 1'b1;
        out_ready = 1'b1;
        repeat (DEPTH + 2*LAT + 6) step();
        bmon = 1'b0;
        out_ready = 1'b0;
        check("R4 drained entries", b_pops, DEPTH);
        check("R6 odd-sized rises", b_wrong, 0);
        check("R6 number of returns", b_rises, DEPTH / BUNDLE);
        check("R6 window back", int'(credit_level), DEPTH);

        // random traffic
        for (int k = 0; k < 4000; k++) begin
            in_valid  = ($urandom % 3) != 0;
            in_data   = DATA_W'($urandom);
            out_ready = ($urandom % 4) != 0;
            if ((k % 500) > 430) out_ready = 1'b0;
            step();
        end

        settle();
        check("R10 final level", int'(credit_level), DEPTH);
        check("R10 fifo empty", int'(out_valid), 0);
        check("R10 scoreboard empty", sb.size(), 0);
        check("R9 err/bound events", err_seen, 0);
        check("R9 err flag", int'(credit_err), 0);

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

endmodule